// File: doc/BRIEF.md
# Triggered One-Shot Sample Capture

This block records a stream of 8-bit samples into a 128-entry on-chip buffer at a rate that software programs. Software sets a 16-bit interval, then arms a single capture pass through a register write. The block takes one sample each time its interval counter runs out, fills the buffer from entry 0 upward, and stops by itself once the last entry is written. The finished buffer therefore holds one coherent record that later activity on the sample input cannot overwrite.

Software reads the record back through one data address. Every read returns the entry under a read pointer, and the pointer then moves to the next entry. It wraps from the last entry back to the first. A small status word shows whether a pass is running and whether a pass has completed. All bus reads return their data one clock after the read strobe.

Top module: `sample_capture`

## Requirements
- R1: After synchronous reset, cap_busy and cap_done are 0, the interval register reads 0 and the read pointer is at entry 0.
- R2: A write to address 0 loads the 16-bit interval register, and a read of address 0 returns the value written.
- R3: A write to address 1 with data bit 0 set, made while no pass is running, makes cap_busy 1 and cap_done 0 from the next clock. A write to address 1 with bit 0 clear has no effect.
- R4: With interval value N, the pass stores its k-th sample (k from 0) at the (k+1)*(N+1)-th rising edge after the arming edge. It takes the value present on sample_in just before that edge. N = 0 stores a sample on every clock.
- R5: After exactly 128 stored samples, cap_busy falls and cap_done rises on the same edge, and the buffer no longer changes.
- R6: An arming write made while a pass is running is ignored: the pass keeps its pointer and timing and ends on the original schedule.
- R7: A read of address 2 returns, one clock later in the low 8 bits, the entry under the read pointer and advances the pointer by one, wrapping from entry 127 to entry 0.
- R8: An accepted arming write returns the read pointer to entry 0.
- R9: A read of address 3 returns cap_busy in bit 0 and cap_done in bit 1, with all other bits 0.
- R10: A read of address 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 interval, 1 arm, 2 data, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid one clock after the read strobe |
| sample_in | input | 8 | Sample stream |
| cap_busy | output | 1 | A capture pass is in progress |
| cap_done | output | 1 | The last pass filled the buffer |

## Verification
The bench checks every stored entry against the sample_in value it computes for the exact storing edge, using interval values of 0, 3, 40 and random ones. An off-by-one in the reload would shift every entry and break those comparisons. It counts the clocks to the end of a pass, so a block that stops one sample early or late, or that keeps writing after the buffer is full, is caught. It re-arms in the middle of a pass to catch a block that restarts its pointer. It also reads 129 entries to catch a read pointer that does not wrap, and re-arms after a partial readback to catch a read pointer that is not returned to entry 0.

// File: rtl/sample_capture_pkg.sv
package sample_capture_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_RATE = 2'd0,
    REG_ARM  = 2'd1,
    REG_DATA = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cap_regs.sv
module cap_regs
  import sample_capture_pkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int RATE_W   = 16,
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                busy,
  input  logic                done,
  input  logic [SAMPLE_W-1:0] buf_q,
  output logic [RATE_W-1:0]   rate_reg,
  output logic                arm_req,
  output logic                data_rd,
  output logic [BUS_W-1:0]    bus_rdata
);
  logic [BUS_W-1:0] reg_q;
  logic             sel_data_q;

  assign arm_req = bus_wr && (bus_addr == REG_ARM) && bus_wdata[0];
  assign data_rd = bus_rd && (bus_addr == REG_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_reg <= '0;
    end else if (bus_wr && (bus_addr == REG_RATE)) begin
      rate_reg <= bus_wdata[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= '0;
      sel_data_q <= 1'b0;
    end else if (bus_rd) begin
      sel_data_q <= (bus_addr == REG_DATA);
      case (bus_addr)
        REG_RATE: reg_q <= BUS_W'(rate_reg);
        REG_STAT: reg_q <= BUS_W'({done, busy});
        default:  reg_q <= '0;
      endcase
    end
  end

  assign bus_rdata = sel_data_q ? BUS_W'(buf_q) : reg_q;
endmodule

// File: rtl/cap_pacer.sv
module cap_pacer #(
  parameter int DEPTH  = 128,
  parameter int RATE_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_req,
  input  logic [RATE_W-1:0] rate_reg,
  output logic              arm_taken,
  output logic              busy,
  output logic              done,
  output logic              store_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [RATE_W-1:0] rate_cnt
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  assign arm_taken = arm_req && !busy;
  assign store_en  = busy && (rate_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      wr_ptr   <= '0;
      rate_cnt <= '0;
    end else if (arm_taken) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      wr_ptr   <= '0;
      rate_cnt <= rate_reg;
    end else if (busy) begin
      if (rate_cnt == '0) begin
        rate_cnt <= rate_reg;
        if (wr_ptr == LAST) begin
          wr_ptr <= '0;
          busy   <= 1'b0;
          done   <= 1'b1;
        end else begin
          wr_ptr <= wr_ptr + 1'b1;
        end
      end else begin
        rate_cnt <= rate_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cap_readptr.sv
module cap_readptr #(
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_taken,
  input  logic             data_rd,
  output logic [PTR_W-1:0] rd_ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || arm_taken) begin
      rd_ptr <= '0;
    end else if (data_rd) begin
      rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/cap_buffer.sv
module cap_buffer #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/sample_capture.sv
module sample_capture
  import sample_capture_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int SAMPLE_W = 8,
  parameter int RATE_W   = 16,
  parameter int BUS_W    = 16,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                cap_busy,
  output logic                cap_done
);
  logic [RATE_W-1:0]   rate_reg;
  logic [RATE_W-1:0]   rate_cnt;
  logic                arm_req;
  logic                arm_taken;
  logic                data_rd;
  logic                store_en;
  logic [PTR_W-1:0]    wr_ptr;
  logic [PTR_W-1:0]    rd_ptr;
  logic [SAMPLE_W-1:0] buf_q;

  cap_regs #(.BUS_W(BUS_W), .RATE_W(RATE_W), .SAMPLE_W(SAMPLE_W)) regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .busy(cap_busy), .done(cap_done),
    .buf_q(buf_q), .rate_reg(rate_reg), .arm_req(arm_req),
    .data_rd(data_rd), .bus_rdata(bus_rdata)
  );

  cap_pacer #(.DEPTH(DEPTH), .RATE_W(RATE_W)) pacer_i (
    .clk(clk), .rst(rst), .arm_req(arm_req), .rate_reg(rate_reg),
    .arm_taken(arm_taken), .busy(cap_busy), .done(cap_done),
    .store_en(store_en), .wr_ptr(wr_ptr), .rate_cnt(rate_cnt)
  );

  cap_readptr #(.DEPTH(DEPTH)) rdptr_i (
    .clk(clk), .rst(rst), .arm_taken(arm_taken), .data_rd(data_rd),
    .rd_ptr(rd_ptr)
  );

  cap_buffer #(.DEPTH(DEPTH), .DATA_W(SAMPLE_W)) buf_i (
    .clk(clk), .we(store_en), .waddr(wr_ptr), .wdata(sample_in),
    .re(data_rd), .raddr(rd_ptr), .q(buf_q)
  );
endmodule

// File: rtl/sample_capture_chk.sv
module sample_capture_chk
  import sample_capture_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int BUS_W  = 16,
  parameter int RATE_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              cap_busy,
  input logic              cap_done,
  input logic              store_en,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic [RATE_W-1:0] rate_cnt
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  logic arm_wr;
  logic rd_hit;
  assign arm_wr = bus_wr && (bus_addr == REG_ARM) && bus_wdata[0];
  assign rd_hit = bus_rd && (bus_addr == REG_DATA);

  p_arm_starts_r3: assert property (@(posedge clk) disable iff (rst)
    (arm_wr && !cap_busy) |=> (cap_busy && !cap_done));

  p_no_store_idle_r5: assert property (@(posedge clk) disable iff (rst)
    store_en |-> cap_busy);

  p_full_stops_r5: assert property (@(posedge clk) disable iff (rst)
    (store_en && wr_ptr == LAST) |=> (!cap_busy && cap_done));

  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(cap_busy && cap_done));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (store_en && wr_ptr != LAST) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

  p_rearm_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (arm_wr && cap_busy && !store_en) |=> (wr_ptr == $past(wr_ptr) && rate_cnt == $past(rate_cnt) - 1'b1));

  p_rd_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && rd_ptr == LAST && !(arm_wr && !cap_busy)) |=> (rd_ptr == '0));
endmodule

bind sample_capture sample_capture_chk #(.DEPTH(DEPTH), .BUS_W(BUS_W), .RATE_W(RATE_W)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .cap_busy(cap_busy), .cap_done(cap_done),
  .store_en(store_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rate_cnt(rate_cnt)
);

// File: tb/sample_capture_tb_top.sv
`timescale 1ns/1ps
module sample_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic [7:0]  sample_in = '0;
  logic        cap_busy;
  logic        cap_done;

  int ncount = 0;
  int total = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] exp_mem [128];

  always #2.5 clk = ~clk;

  sample_capture dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sample_in(sample_in), .cap_busy(cap_busy), .cap_done(cap_done)
  );

  function automatic logic [7:0] smp(int n);
    logic [31:0] v;
    v = n * 37 + 11;
    return v[7:0] ^ v[10:3];
  endfunction

  always @(negedge clk) begin
    ncount    <= ncount + 1;
    sample_in <= smp(ncount + 1);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_to(int n);
    while (ncount < n) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); #1;
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  // Arms a pass; returns the ncount of the negedge before the arming edge.
  task automatic arm(output int tn);
    @(negedge clk); #1;
    bus_addr = 2'd1; bus_wdata = 16'h0001; bus_wr = 1'b1;
    tn = ncount;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic fill_expect(int tn, int r);
    for (int k = 0; k < 128; k++) exp_mem[k] = smp(tn + (k + 1) * (r + 1));
  endtask

  task automatic run_pass(int r, bit rearm_mid, string tag);
    int tn;
    logic [15:0] v;
    bus_write(2'd0, 16'(r));
    arm(tn);
    fill_expect(tn, r);
    check({tag, " R3 busy after arm"}, cap_busy, 1);
    check({tag, " R3 done cleared"}, cap_done, 0);
    if (rearm_mid) begin
      wait_to(tn + 60 * (r + 1) + 1);
      arm(v);
      check({tag, " R6 rearm keeps busy"}, cap_busy, 1);
    end
    bus_read(2'd3, v);
    check({tag, " R9 status busy"}, v, 16'h0001);
    wait_to(tn + 128 * (r + 1));
    check({tag, " R5 busy before last"}, cap_busy, 1);
    wait_to(tn + 128 * (r + 1) + 1);
    check({tag, " R5 busy fell"}, cap_busy, 0);
    check({tag, " R5 done rose"}, cap_done, 1);
  endtask

  task automatic read_all(string tag);
    logic [15:0] v;
    for (int k = 0; k < 128; k++) begin
      bus_read(2'd2, v);
      check({tag, " R4 entry"}, v, {8'h00, exp_mem[k]});
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int tn;
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    check("R1 busy reset", cap_busy, 0);
    check("R1 done reset", cap_done, 0);
    bus_read(2'd0, v);
    check("R1 rate reset", v, 0);
    bus_read(2'd3, v);
    check("R9 status idle", v, 0);

    bus_write(2'd0, 16'hA5C3);
    bus_read(2'd0, v);
    check("R2 rate readback", v, 16'hA5C3);
    bus_read(2'd1, v);
    check("R10 arm reads zero", v, 0);

    bus_write(2'd1, 16'h0002);
    check("R3 bit0 clear ignored", cap_busy, 0);

    run_pass(0, 0, "rate0");
    repeat (30) @(negedge clk);
    bus_read(2'd3, v);
    check("R9 status done", v, 16'h0002);
    read_all("rate0 R5");
    bus_read(2'd2, v);
    check("R7 wrap to entry 0", v, {8'h00, exp_mem[0]});

    run_pass(3, 1, "rate3");
    read_all("rate3 R6");

    for (int k = 0; k < 5; k++) bus_read(2'd2, v);
    run_pass(1, 0, "rate1");
    bus_read(2'd2, v);
    check("R8 read pointer reset", v, {8'h00, exp_mem[0]});
    bus_read(2'd2, v);
    check("R7 advance", v, {8'h00, exp_mem[1]});

    run_pass(40, 0, "rate40");
    read_all("rate40");

    for (int i = 0; i < 3; i++) begin
      run_pass(int'($urandom_range(0, 6)), 0, "random");
      read_all("random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule